// File: doc/BRIEF.md
# Nibble-Packed Priority Interrupt Controller

This block gathers 28 interrupt requests and presents the CPU with one priority level and one vector. Software reaches the block through a small register port. Four 32-bit control words each pack eight 4-bit source fields. A fifth word selects the active edge of the edge-sensitive sources. Each field holds a 3-bit priority and a qualifier bit. A write touches only the fields whose qualifier bit is set, so software can change one source without a read-modify-write. The same write also acknowledges a latched edge request.

Six of the sources are edge-sensitive. Each passes through a two-flop synchroniser and an edge detector, then sets a pending flag that holds until software acknowledges it. The other 22 sources are level-sensitive and follow their inputs directly. A priority of 0 masks a source. The arbiter picks the highest nonzero level among the active sources. When two sources share that level, the lower source index wins.

Top module: `nibble_irq_ctrl`

## Requirements
- R1: After reset, every priority is 0, every pending flag is clear and every polarity bit is 1. Control words 0 to 3 read 0x00000000 and word 4 reads 0x0000003F. `irq_lvl_o` is 0 and `irq_vec_o` equals VEC_BASE (64).
- R2: Source s lives in control word s/8, at bits [31-4*(s%8) : 28-4*(s%8)]. In each field, bits 2:0 are the priority and bit 3 is the qualifier or flag.
  - Indices 0-3 and 25-26 are the edge sources, called ext1-ext4 and ext5-ext6.
  - All other indices are level sources.
  - Word 3 uses only its top four fields.
- R3: A write whose field bit 3 is 1 loads that field's bits 2:0 into the priority. A field written with bit 3 at 0 keeps its priority. Bits [15:0] of word 3 and addresses 5-7 ignore writes and read as 0.
- R4: A level source is active while its input is 1. Reading its field returns the input level in bit 3.
- R5: An edge source is synchronised by two flops and then edge-detected against its previous synchronised value. The detected edge sets the pending flag.
  - Word 4 bit k selects the edge for ext(k+1): 1 selects rising and 0 selects falling.
  - The edge of the other sense has no effect.
  - Pending shows in field bit 3 and in the outputs at the third rising clock edge after the input changes.
- R6: Writing an edge source's field with bit 3 set clears its pending flag. This holds both for an acknowledge that keeps the priority and for a masking write with priority 0.
- R7: An edge that is detected in the same cycle as a clearing write leaves the source pending.
- R8: `irq_lvl_o` is the highest priority among active sources with nonzero priority. Ties go to the lower index, and `irq_vec_o` is VEC_BASE+1+index. With no such source, the outputs are 0 and VEC_BASE. The outputs follow the register state combinationally.
- R9: A source with priority 0 never drives the outputs, even while its input is active or its edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 28 | Source requests, indexed in field order |
| addr_i | input | 3 | Register select: 0-3 control words, 4 polarity |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_lvl_o | output | 3 | Highest active priority level |
| irq_vec_o | output | 8 | Vector of the winning source |

## Verification
Writes take effect at the clock edge that samples the strobe. Reads and the level and vector outputs are combinational, so the bench samples them at the falling edge after a write, or 1 ns after an input change on a level source.

An edge input that changes before clock edge k first appears as pending after edge k+2. The bench therefore checks that nothing is pending at the second falling edge and that the request shows at the third.

To exercise the case where an edge meets an acknowledge, the bench drives the clearing write at the falling edge that falls between the edges at which the edge is detected and latched. Both events then land on the same clock edge.

// File: rtl/nibble_irq_pkg.sv
package nibble_irq_pkg;
  localparam int NUM_SRC = 28;
  localparam int NUM_EXT = 6;
  localparam int NUM_REG = 4;
  localparam int FIELDS  = 8;
  localparam int PRIO_W  = 3;
  localparam logic [31:0] EXT_MAP = 32'h0600_000F;

  function automatic int ext_slot(input int s);
    int n = 0;
    for (int i = 0; i < s; i++) if (EXT_MAP[i]) n++;
    return n;
  endfunction

  function automatic int ext_src(input int k);
    int n = 0;
    for (int i = 0; i < 32; i++)
      if (EXT_MAP[i]) begin
        if (n == k) return i;
        n++;
      end
    return 0;
  endfunction

  function automatic int fld_lsb(input int s);
    return 28 - 4 * (s % FIELDS);
  endfunction
endpackage

// File: rtl/nibble_irq_edge.sv
module nibble_irq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], lvl_i};

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  assign edge_o = rise_sel_i ? ( sh_q[STAGES-1] & ~sh_q[STAGES])
                             : (~sh_q[STAGES-1] &  sh_q[STAGES]);
endmodule

// File: rtl/nibble_irq_arb.sv
module nibble_irq_arb #(
  parameter int N  = 28,
  parameter int PW = 3,
  parameter int IW = 5
) (
  input  logic [N-1:0]    act_i,
  input  logic [N*PW-1:0] prio_i,
  output logic [PW-1:0]   lvl_o,
  output logic [IW-1:0]   idx_o,
  output logic            hit_o
);
  always_comb begin
    lvl_o = '0;
    idx_o = '0;
    // strict compare: lower index keeps ties, priority 0 never wins
    for (int i = 0; i < N; i++)
      if (act_i[i] && (prio_i[i*PW +: PW] > lvl_o)) begin
        lvl_o = prio_i[i*PW +: PW];
        idx_o = IW'(i);
      end
    hit_o = (lvl_o != '0);
  end
endmodule

// File: rtl/nibble_irq_ctrl.sv
module nibble_irq_ctrl
  import nibble_irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int ADDR_W   = 3,
  parameter int SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  irq_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [PRIO_W-1:0]   irq_lvl_o,
  output logic [VEC_W-1:0]    irq_vec_o
);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int POL_ADDR = NUM_REG;

  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]        flag_w;
  logic [NUM_EXT-1:0]        pol_q, pend_q, edge_w, clr_w;
  logic [PRIO_W-1:0]         win_lvl;
  logic [IDX_W-1:0]          win_idx;
  logic                      win_hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                          pol_q <= '1;
    else if (wr_en_i && addr_i == ADDR_W'(POL_ADDR))      pol_q <= wdata_i[NUM_EXT-1:0];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int REG = s / FIELDS;
    localparam int LSB = fld_lsb(s);
    logic ld;
    assign ld = wr_en_i && (addr_i == ADDR_W'(REG)) && wdata_i[LSB+3];

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) prio_q[s*PRIO_W +: PRIO_W] <= '0;
      else if (ld) prio_q[s*PRIO_W +: PRIO_W] <= wdata_i[LSB +: PRIO_W];

    if (EXT_MAP[s]) begin : g_ext
      assign clr_w[ext_slot(s)] = ld;
      assign flag_w[s]          = pend_q[ext_slot(s)];
    end else begin : g_lvl
      assign flag_w[s] = irq_i[s];
    end
  end

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_edge
    nibble_irq_edge #(.STAGES(SYNC_STG)) u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (irq_i[ext_src(k)]),
      .rise_sel_i (pol_q[k]),
      .edge_o     (edge_w[k])
    );

    // a new edge beats a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) pend_q[k] <= 1'b0;
      else         pend_q[k] <= edge_w[k] | (pend_q[k] & ~clr_w[k]);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(POL_ADDR)) rdata_o[NUM_EXT-1:0] = pol_q;
    else
      for (int s = 0; s < NUM_SRC; s++)
        if (addr_i == ADDR_W'(s / FIELDS))
          rdata_o[fld_lsb(s) +: 4] = {flag_w[s], prio_q[s*PRIO_W +: PRIO_W]};
  end

  nibble_irq_arb #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb (
    .act_i  (flag_w),
    .prio_i (prio_q),
    .lvl_o  (win_lvl),
    .idx_o  (win_idx),
    .hit_o  (win_hit)
  );

  assign irq_lvl_o = win_lvl;
  assign irq_vec_o = win_hit ? VEC_W'(VEC_BASE + 1) + VEC_W'(win_idx) : VEC_W'(VEC_BASE);
endmodule

// File: rtl/nibble_irq_chk.sv
module nibble_irq_chk
  import nibble_irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int ADDR_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [PRIO_W-1:0]   irq_lvl_o,
  input logic [VEC_W-1:0]    irq_vec_o,
  input logic [NUM_EXT-1:0]  pend_q,
  input logic [NUM_EXT-1:0]  edge_w
);
  a_r8_idle_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lvl_o == '0 |-> irq_vec_o == VEC_W'(VEC_BASE));

  a_r8_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lvl_o != '0 |-> (irq_vec_o > VEC_W'(VEC_BASE)) &&
                        (irq_vec_o <= VEC_W'(VEC_BASE + NUM_SRC)));

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_k
    localparam int SRC = ext_src(k);
    localparam int LSB = fld_lsb(SRC);

    a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(SRC / FIELDS) && wdata_i[LSB+3] && !edge_w[k])
      |=> !pend_q[k]);

    a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_w[k] |=> pend_q[k]);

    a_r5_set_by_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q[k] && !edge_w[k]) |=> !pend_q[k]);
  end
endmodule

bind nibble_irq_ctrl nibble_irq_chk #(
  .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o),
  .pend_q(pend_q), .edge_w(edge_w)
);

// File: tb/sim_nibble_irq_ctrl.sv
module sim_nibble_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] irq;
  logic [2:0]  addr;
  logic        wr_en;
  logic [31:0] wdata, rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nibble_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_lvl_o(lvl), .irq_vec_o(vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  function automatic logic [31:0] fld(input int s, input logic [3:0] n);
    return {28'd0, n} << (28 - 4 * (s % 8));
  endfunction

  task automatic set_fld(input int s, input logic [3:0] n);
    wr(3'(s / 8), fld(s, n));
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_fld(input int s, output logic [31:0] d);
    logic [31:0] w;
    rd(3'(s / 8), w);
    d = (w >> (28 - 4 * (s % 8))) & 32'hF;
  endtask

  task automatic chk_out(input string req, input int l, input int v);
    #1;
    chk({req, " level"}, 32'(lvl), 32'(l));
    chk({req, " vector"}, 32'(vec), 32'(v));
  endtask

  function automatic bit is_ext(input int s);
    return (s < 4) || (s == 25) || (s == 26);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk("R1 control word", d, 32'h0);
    end
    rd(3'd4, d); chk("R1 polarity word", d, 32'h3F);
    chk_out("R1", 0, 64);

    // R2/R3/R4/R5/R6/R9 sweep over every source
    for (int s = 0; s < 28; s++) begin
      int p;
      p = s % 7 + 1;
      set_fld(s, 4'(8 + p));
      rd_fld(s, d); chk("R2 R3 field load", d, 32'(p));
      if (is_ext(s)) begin
        irq[s] = 1'b1;
        tick(2); chk_out("R5 latency not yet", 0, 64);
        tick(1); chk_out("R5 R8 pending", p, 65 + s);
        rd_fld(s, d); chk("R5 pending flag", d, 32'(8 + p));
        irq[s] = 1'b0;
        tick(4); chk_out("R5 other edge ignored", p, 65 + s);
        set_fld(s, 4'(8 + p));
        chk_out("R6 ack clears", 0, 64);
        rd_fld(s, d); chk("R6 ack keeps priority", d, 32'(p));
        irq[s] = 1'b1;
        tick(3); chk_out("R5 second edge", p, 65 + s);
        set_fld(s, 4'h8);
        rd_fld(s, d); chk("R6 mask clears", d, 32'h0);
        irq[s] = 1'b0;
        tick(4);
        irq[s] = 1'b1;
        tick(3); chk_out("R9 masked edge", 0, 64);
        rd_fld(s, d); chk("R9 pending while masked", d, 32'h8);
        set_fld(s, 4'h8);
        irq[s] = 1'b0;
        tick(4);
      end else begin
        irq[s] = 1'b1;
        chk_out("R4 R8 level source", p, 65 + s);
        rd_fld(s, d); chk("R4 input flag", d, 32'(8 + p));
        set_fld(s, 4'h8);
        chk_out("R9 masked level", 0, 64);
        rd_fld(s, d); chk("R9 masked flag", d, 32'h8);
        irq[s] = 1'b0;
        #1;
        rd_fld(s, d); chk("R4 input low", d, 32'h0);
      end
    end

    // R3 qualifier bit at 0 leaves priority
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd1, 32'h7777_7777);
    rd(3'd1, d); chk("R3 unqualified write", d, 32'h7777_7777);
    wr(3'd1, 32'h8888_8888);
    rd(3'd1, d); chk("R3 mask all", d, 32'h0);

    // R3 unused fields and addresses
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R3 unused nibbles", d, 32'h7777_0000);
    wr(3'd3, 32'h8888_8888);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R3 unmapped read", d, 32'h0);
    rd(3'd4, d); chk("R3 polarity untouched", d, 32'h3F);
    rd(3'd0, d); chk("R3 word0 untouched", d, 32'h0);

    // R8 tie at equal priority, then a higher one
    for (int a = 0; a < 4; a++) wr(3'(a), 32'hCCCC_CCCC);
    irq[27] = 1'b1; irq[10] = 1'b1;
    chk_out("R8 tie lower index", 4, 75);
    set_fld(27, 4'hE);
    chk_out("R8 higher level", 6, 92);
    irq[27] = 1'b0; irq[10] = 1'b0;
    for (int a = 0; a < 4; a++) wr(3'(a), 32'h8888_8888);

    // R8 mixed priorities
    set_fld(5, 4'hA); set_fld(12, 4'hE); set_fld(20, 4'hE); set_fld(8, 4'h9);
    irq[5] = 1'b1; irq[12] = 1'b1; irq[20] = 1'b1; irq[8] = 1'b1;
    chk_out("R8 mixed", 6, 77);
    irq[12] = 1'b0;
    chk_out("R8 next winner", 6, 85);
    irq[20] = 1'b0;
    chk_out("R8 third winner", 2, 70);
    irq = '0;
    for (int a = 0; a < 4; a++) wr(3'(a), 32'h8888_8888);

    // R5 falling polarity on ext1
    wr(3'd4, 32'h3E);
    set_fld(0, 4'hA);
    irq[0] = 1'b1;
    tick(3); chk_out("R5 rising ignored when falling", 0, 64);
    irq[0] = 1'b0;
    tick(2); chk_out("R5 falling latency", 0, 64);
    tick(1); chk_out("R5 falling detected", 2, 65);
    set_fld(0, 4'hA);
    chk_out("R6 ack falling", 0, 64);
    wr(3'd4, 32'h3F);
    set_fld(0, 4'h8);

    // R7 edge coincident with ack on ext2
    set_fld(1, 4'hB);
    irq[1] = 1'b1;
    tick(3); chk_out("R7 first pending", 3, 66);
    irq[1] = 1'b0;
    tick(4);
    irq[1] = 1'b1;
    tick(1);
    wr(3'd0, fld(1, 4'hB));
    chk_out("R7 edge beats ack", 3, 66);
    set_fld(1, 4'hB);
    chk_out("R7 later ack clears", 0, 64);
    irq[1] = 1'b0;
    set_fld(1, 4'h8);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule